// File: doc/BRIEF.md
# Prescaled Match Timer

This block is an up-counting timer whose count advances once per prescale period. A prescale counter runs from zero up to a programmable limit. When it reaches that limit it wraps to zero and produces one count tick. The main counter is compared with a set of match values on every tick.

Each match channel has its own enable bits. These choose whether a match sets a sticky interrupt flag, returns the counter to zero, halts the counter, or toggles a dedicated output pin. Any combination of these actions may be enabled on one channel. The flags are cleared by writing ones on a clear vector.

Software-side logic starts the timer with a one-cycle start pulse and halts it with a one-cycle halt pulse. A stop-on-match halts the timer in the same way. Once halted, the counter stays frozen until the next start pulse.

Top module: `match_timer`

## Requirements
- R1: After reset, `count` is 0, `running` is 0, and every bit of `irq_flag` and `match_pin` is 0.
- R2: While running with prescale limit P, `count` increases by exactly one for every P+1 running clock cycles. The first increment comes on the (P+1)-th running cycle.
- R3: A `start` pulse sets `running`. A `halt` pulse clears it, and halt wins when both are high. While not running, `count`, the prescale phase and `match_pin` all hold their values, and counting later resumes from the held prescale phase.
- R4: On a tick where `count` equals match value i, `irq_flag[i]` sets if `irq_en[i]` is 1. If `irq_en[i]` is 0, that flag does not set.
- R5: On a tick where channel i matches and `rst_en[i]` is 1, the next count value is 0 instead of count+1.
- R6: On a tick where channel i matches and `stop_en[i]` is 1, `count` keeps the matched value and `running` clears. The counter stays frozen until `start` is pulsed again.
- R7: When several channels match on one tick, all of their enabled flags set on the same edge. Stop has priority over reset: the count holds and does not go to 0.
- R8: A 1 on `irq_clr[i]` clears `irq_flag[i]` on the next edge. If a new match sets the same flag on that edge, the set wins.
- R9: On every match of channel i with `pin_en[i]` = 1, `match_pin[i]` toggles. With `pin_en[i]` = 0, the pin holds its value.
- R10: Match value i occupies `match_val[i*CW +: CW]`. Bit i of `irq_en`, `rst_en`, `stop_en`, `pin_en` and `irq_clr` belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that sets the run flag |
| halt | input | 1 | Pulse that clears the run flag |
| psc_max | input | PW | Prescale limit P; one tick every P+1 cycles |
| match_val | input | NM*CW | Packed match values, channel i at bits i*CW +: CW |
| irq_en | input | NM | Per-channel flag enable |
| rst_en | input | NM | Per-channel reset-on-match enable |
| stop_en | input | NM | Per-channel stop-on-match enable |
| pin_en | input | NM | Per-channel pin toggle enable |
| irq_clr | input | NM | Write-one-to-clear for the flags |
| count | output | CW | Timer count |
| running | output | 1 | Run flag |
| irq_flag | output | NM | Sticky match flags |
| match_pin | output | NM | Match output pins |

## Verification
The assertions check, on every cycle, that an idle timer keeps its count and pins frozen. They also check that a flag never drops without its clear bit, that a flag never rises while its enable was low, and that the count only ever holds, steps by one, or returns to zero. Only the bench scenarios can show the exact tick spacing for each prescale limit, and which match value triggers which action. The same applies to the stop-over-reset priority, the set-over-clear rule on a shared edge, and the restart after a stop. The bench sweeps the prescale limit and the match value and computes the count, flag and pin values with arithmetic.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CW = 32,
  parameter int NM = 4,
  parameter int PW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic [PW-1:0]    psc_max,
  input  logic [NM*CW-1:0] match_val,
  input  logic [NM-1:0]    irq_en,
  input  logic [NM-1:0]    rst_en,
  input  logic [NM-1:0]    stop_en,
  input  logic [NM-1:0]    pin_en,
  input  logic [NM-1:0]    irq_clr,
  output logic [CW-1:0]    count,
  output logic             running,
  output logic [NM-1:0]    irq_flag,
  output logic [NM-1:0]    match_pin
);

  logic [PW-1:0] pc;
  logic          tick;
  logic [NM-1:0] hit;
  logic          do_stop;
  logic          do_rst;

  assign tick = running && (pc >= psc_max);

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    assign hit[i] = tick && (count == match_val[i*CW +: CW]);
  end

  assign do_stop = |(hit & stop_en);
  assign do_rst  = |(hit & rst_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      count     <= '0;
      running   <= 1'b0;
      irq_flag  <= '0;
      match_pin <= '0;
    end else begin
      if (running) pc <= tick ? '0 : pc + PW'(1);

      if (do_stop)     count <= count;
      else if (do_rst) count <= '0;
      else if (tick)   count <= count + CW'(1);

      if (halt || do_stop) running <= 1'b0;
      else if (start)      running <= 1'b1;

      irq_flag  <= (irq_flag & ~irq_clr) | (hit & irq_en);
      match_pin <= match_pin ^ (hit & pin_en);
    end
  end

endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CW = 32,
  parameter int NM = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] irq_en,
  input logic [NM-1:0] irq_clr,
  input logic [CW-1:0] count,
  input logic          running,
  input logic [NM-1:0] irq_flag,
  input logic [NM-1:0] match_pin
);

  assert_idle_count_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count));

  assert_idle_pins_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(match_pin));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_flag & ~irq_clr)) |=> ((irq_flag & $past(irq_flag & ~irq_clr)) == $past(irq_flag & ~irq_clr)));

  assert_flag_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~irq_flag & ~irq_en)) |=> ((irq_flag & $past(~irq_flag & ~irq_en)) == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ((count == $past(count)) || (count - $past(count) == CW'(1)) || (count == '0)));

endmodule

bind match_timer match_timer_chk #(.CW(CW), .NM(NM)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_clr(irq_clr),
  .count(count), .running(running), .irq_flag(irq_flag), .match_pin(match_pin)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
  localparam int CW = 32;
  localparam int NM = 4;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n, start, halt;
  logic [PW-1:0] psc_max;
  logic [NM*CW-1:0] match_val;
  logic [NM-1:0] irq_en, rst_en, stop_en, pin_en, irq_clr;
  logic [CW-1:0] count;
  logic running;
  logic [NM-1:0] irq_flag, match_pin;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  match_timer #(.CW(CW), .NM(NM), .PW(PW)) u_match_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .psc_max(psc_max),
    .match_val(match_val), .irq_en(irq_en), .rst_en(rst_en), .stop_en(stop_en),
    .pin_en(pin_en), .irq_clr(irq_clr), .count(count), .running(running),
    .irq_flag(irq_flag), .match_pin(match_pin)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; halt = 1'b0; psc_max = PW'(p);
    match_val = '1; irq_en = '0; rst_en = '0; stop_en = '0; pin_en = '0; irq_clr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_m(input int i, input int v);
    match_val[i*CW +: CW] = CW'(v);
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(0);
    @(negedge clk);
    chk("R1 count", 64'(count), 0);
    chk("R1 running", 64'(running), 0);
    chk("R1 flags", 64'(irq_flag), 0);
    chk("R1 pins", 64'(match_pin), 0);

    // R2 free-running tick spacing
    for (int p = 0; p < 4; p++) begin
      do_reset(p);
      go();
      for (int n = 1; n <= 24; n++) begin
        @(negedge clk);
        chk("R2 count", 64'(count), 64'(n / (p + 1)));
      end
    end

    // R3 halt, hold, resume from held phase, halt wins over start
    do_reset(2);
    go();
    repeat (6) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 held count", 64'(count), 2);
    chk("R3 running low", 64'(running), 0);
    go();
    repeat (2) @(negedge clk);
    chk("R3 resumed count", 64'(count), 3);
    halt = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; halt = 1'b0;
    chk("R3 halt beats start", 64'(running), 0);

    // R4 R5 R9 R10 reset-on-match sweep over channels
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 4; m++) begin
        automatic int ch = m % NM;
        automatic logic [NM-1:0] bit_i = NM'(1) << ch;
        do_reset(p);
        set_m(ch, m);
        rst_en = bit_i;
        irq_en = (p != 1) ? bit_i : '0;
        pin_en = (p != 2) ? bit_i : '0;
        go();
        for (int n = 1; n <= 30; n++) begin
          automatic int t = n / (p + 1);
          automatic int hits = t / (m + 1);
          @(negedge clk);
          chk("R5 count", 64'(count), 64'(t % (m + 1)));
          chk("R4 flag", 64'(irq_flag), (p != 1 && hits > 0) ? 64'(bit_i) : 0);
          chk("R9 pin", 64'(match_pin), (p != 2 && (hits % 2) == 1) ? 64'(bit_i) : 0);
        end
      end
    end

    // R6 stop-on-match sweep
    for (int p = 0; p < 2; p++) begin
      for (int m = 1; m <= 4; m++) begin
        automatic int ch = (m + 1) % NM;
        automatic logic [NM-1:0] bit_i = NM'(1) << ch;
        do_reset(p);
        set_m(ch, m);
        stop_en = bit_i;
        irq_en = bit_i;
        go();
        for (int n = 1; n <= (m + 3) * (p + 1); n++) begin
          automatic int t = n / (p + 1);
          @(negedge clk);
          chk("R6 count", 64'(count), 64'((t < m) ? t : m));
          chk("R6 running", 64'(running), (t <= m) ? 1 : 0);
          chk("R6 flag", 64'(irq_flag), (t > m) ? 64'(bit_i) : 0);
        end
      end
    end

    // R6 frozen until restart, then continues to a new match
    do_reset(1);
    set_m(1, 2);
    stop_en = 4'b0010;
    go();
    repeat (8) @(negedge clk);
    chk("R6 stopped", 64'(count), 2);
    repeat (4) @(negedge clk);
    chk("R6 still frozen", 64'(count), 2);
    set_m(1, 4);
    go();
    repeat (4) @(negedge clk);
    chk("R6 restart count", 64'(count), 4);
    chk("R6 restart running", 64'(running), 1);
    repeat (2) @(negedge clk);
    chk("R6 second stop count", 64'(count), 4);
    chk("R6 second stop running", 64'(running), 0);

    // R7 simultaneous matches, stop beats reset
    do_reset(0);
    set_m(0, 3); set_m(1, 3); set_m(2, 3);
    rst_en = 4'b0001; stop_en = 4'b0100; irq_en = 4'b0111;
    go();
    repeat (3) @(negedge clk);
    chk("R7 before match", 64'(irq_flag), 0);
    @(negedge clk);
    chk("R7 count held", 64'(count), 3);
    chk("R7 running", 64'(running), 0);
    chk("R7 flags together", 64'(irq_flag), 64'h7);

    // R8 write-one-to-clear
    irq_clr = 4'b0010;
    @(negedge clk);
    irq_clr = '0;
    chk("R8 clear one", 64'(irq_flag), 64'h5);

    // R8 set wins over clear on the same edge
    do_reset(0);
    set_m(3, 2);
    rst_en = 4'b1000; irq_en = 4'b1000;
    go();
    repeat (2) @(negedge clk);
    irq_clr = 4'b1000;
    @(negedge clk);
    irq_clr = '0;
    chk("R8 set wins", 64'(irq_flag), 64'h8);
    @(negedge clk);
    irq_clr = 4'b1000;
    @(negedge clk);
    irq_clr = '0;
    chk("R8 cleared", 64'(irq_flag), 0);
    @(negedge clk);
    chk("R8 set again", 64'(irq_flag), 64'h8);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule